// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Data ALU

This block is the arithmetic heart of a 16-bit fixed-point signal-processing core. It holds four 16-bit operand registers (two pairs, X = X1:X0 and Y = Y1:Y0) and two 40-bit accumulators, A and B. Each accumulator is an 8-bit guard extension above a 16-bit high word and a 16-bit low word. In one clock and without a pipeline it forms a fractional 16x16 product and writes it to an accumulator, adds it to one or subtracts it from one. It can also round an accumulator, apply a 16-bit logic operation to the high word of one, load one from an operand pair, or clear one. The next operation always sees the updated accumulator.

A decoder outside the block drives a 4-bit opcode, two operand selects, a destination select, an unsigned-operand bit and a rounding-mode bit. Operand registers are written through a simple load port. Each operation that writes an accumulator updates five condition flags. A read port returns the high word of a chosen accumulator through a saturating limiter, and a sticky flag records any clipping.

Top module: `frac_mac_alu`

## Requirements
- R1: After reset, all four operand registers, both accumulators, the flags and the limit flag are zero.
- R2: Operand select codes are 0=X0, 1=X1, 2=Y0, 3=Y1. MPY (opcode 1) writes the destination (dst 0=A, 1=B) with the signed 16x16 product shifted left one bit and sign-extended to 40 bits.
- R3: When uns_i is 1, MPY, MAC and MSUB treat both operands as unsigned, and the product is zero-extended. uns_i has no effect on any other opcode.
- R4: MAC (opcode 2) adds the product to the full 40-bit destination and MSUB (opcode 3) subtracts it. Operations issued on consecutive cycles chain on the updated value.
- R5: RND (opcode 4) with rnd_tc_i=1 adds 0x8000 to the destination and then clears the low word.
- R6: RND with rnd_tc_i=0 (convergent) behaves the same, except that when the low word was exactly 0x8000 bit 16 of the result is forced to 0.
- R7: AND, OR, EOR (opcodes 5, 6, 7) combine the high word of the destination with the src_a operand, and NOT (opcode 8) inverts that high word. Bits 39:32 and 15:0 stay unchanged.
- R8: MOVE (opcode 9) loads the destination with the pair X1:X0 (src_a bit 1 = 0) or Y1:Y0 (bit 1 = 1), sign-extended to 40 bits. CLR (opcode 10) zeroes the destination.
- R9: The read word is bits 31:16 of the selected accumulator when bits 39:31 all agree. Otherwise it is 0x7FFF (bit 39 = 0) or 0x8000 (bit 39 = 1), and a read with rd_en_i high sets limit_o on the next clock. limit_o stays set until reset.
- R10: flags_o is {E,N,Z,V,C}. N is bit 39 of the result, Z is set when all 40 bits are zero, and E is set when bits 39:31 do not all agree. V and C give signed overflow and carry (borrow for MSUB) for MAC, MSUB and RND, and are 0 for every other opcode.
- R11: A load writes ld_data_i to the register selected by ld_sel_i (same codes as R2) at the clock edge. An operation issued in a later cycle uses the new value.
- R12: Opcode 0 and opcodes 11 to 15 leave both accumulators and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Opcode |
| dst_i | input | 1 | Destination accumulator, 0=A, 1=B |
| src_a_i | input | 2 | First operand select, also selects the pair for MOVE |
| src_b_i | input | 2 | Second multiplier operand select |
| uns_i | input | 1 | Unsigned operands for multiply operations |
| rnd_tc_i | input | 1 | Rounding mode, 1 = two's complement, 0 = convergent |
| ld_en_i | input | 1 | Operand register load strobe |
| ld_sel_i | input | 2 | Operand register to load |
| ld_data_i | input | 16 | Load data |
| rd_en_i | input | 1 | Read strobe, arms the limit flag |
| rd_sel_i | input | 1 | Accumulator to read, 0=A, 1=B |
| rd_data_o | output | 16 | Limited high word of the selected accumulator |
| limit_o | output | 1 | Sticky saturation flag |
| flags_o | output | 5 | {E,N,Z,V,C} of the last writing operation |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |

## Verification
Both accumulators are visible at the ports. A wrong product, carry or rounding decision therefore shows in acc_a_o or acc_b_o at the first sample after the edge that executes the operation, and in flags_o in the same cycle. Any corruption of the guard bits shows up as a changed E flag, and on the read port as a saturated word in place of the expected high word. A bad operand register is found by the next multiply that selects it. A leaky sticky flag is found by the non-clipping read that follows a clipping one.

// File: rtl/frac_alu_pkg.sv
package frac_alu_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_MPY  = 4'd1,
    OP_MAC  = 4'd2,
    OP_MSUB = 4'd3,
    OP_RND  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_EOR  = 4'd7,
    OP_NOT  = 4'd8,
    OP_MOVE = 4'd9,
    OP_CLR  = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic e;
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/fam_mul.sv
module fam_mul #(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              uns_i,
  output logic [ACC_W-1:0]  prod_o
);
  localparam int PAD_W = ACC_W - WORD_W;

  logic signed [ACC_W-1:0] ax, bx, full;

  always_comb begin
    ax   = uns_i ? $signed({{PAD_W{1'b0}}, a_i}) : $signed({{PAD_W{a_i[WORD_W-1]}}, a_i});
    bx   = uns_i ? $signed({{PAD_W{1'b0}}, b_i}) : $signed({{PAD_W{b_i[WORD_W-1]}}, b_i});
    full = ax * bx;
  end

  // fractional alignment: drop redundant sign bit
  assign prod_o = full << 1;
endmodule

// File: rtl/fam_addsub.sv
module fam_addsub #(
  parameter int W = 40
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   t;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    t     = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    sum_o = t[W-1:0];
    c_o   = sub_i ? ~t[W] : t[W];
    v_o   = (a_i[W-1] == b_eff[W-1]) && (t[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/fam_round.sv
module fam_round #(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [WORD_W-1:0]       lsw_i,
  input  logic [ACC_W-WORD_W-1:0] sum_hi_i,
  input  logic                    conv_i,
  output logic [ACC_W-1:0]        rnd_o
);
  localparam logic [WORD_W-1:0] TIE = {1'b1, {(WORD_W-1){1'b0}}};

  logic tie;
  assign tie   = conv_i && (lsw_i == TIE);
  assign rnd_o = {sum_hi_i[ACC_W-WORD_W-1:1], sum_hi_i[0] & ~tie, {WORD_W{1'b0}}};
endmodule

// File: rtl/fam_limit.sv
module fam_limit #(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 8
) (
  input  logic [EXT_W+WORD_W-1:0] hi_i,
  output logic [WORD_W-1:0]       data_o,
  output logic                    sat_o
);
  localparam int TOP = EXT_W + WORD_W - 1;

  logic [EXT_W:0] guard;

  always_comb begin
    guard  = hi_i[TOP:WORD_W-1];
    sat_o  = !((&guard) || !(|guard));
    if (!sat_o)      data_o = hi_i[WORD_W-1:0];
    else if (hi_i[TOP]) data_o = {1'b1, {(WORD_W-1){1'b0}}};
    else             data_o = {1'b0, {(WORD_W-1){1'b1}}};
  end
endmodule

// File: rtl/frac_mac_alu.sv
module frac_mac_alu
  import frac_alu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [3:0]                  op_i,
  input  logic                        dst_i,
  input  logic [1:0]                  src_a_i,
  input  logic [1:0]                  src_b_i,
  input  logic                        uns_i,
  input  logic                        rnd_tc_i,
  input  logic                        ld_en_i,
  input  logic [1:0]                  ld_sel_i,
  input  logic [WORD_W-1:0]           ld_data_i,
  input  logic                        rd_en_i,
  input  logic                        rd_sel_i,
  output logic [WORD_W-1:0]           rd_data_o,
  output logic                        limit_o,
  output logic [4:0]                  flags_o,
  output logic [EXT_W+2*WORD_W-1:0]   acc_a_o,
  output logic [EXT_W+2*WORD_W-1:0]   acc_b_o
);
  localparam int ACC_W  = EXT_W + 2*WORD_W;
  localparam int NREG   = 4;
  localparam int NACC   = 2;
  localparam int MSW_HI = 2*WORD_W - 1;
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (WORD_W-1);

  logic [WORD_W-1:0] in_q  [NREG];
  logic [ACC_W-1:0]  acc_q [NACC];
  alu_flags_t        flags_q, nf;
  logic              limit_q;

  logic [WORD_W-1:0]   opa, opb;
  logic [ACC_W-1:0]    cur, prod, sum, rnd, res;
  logic [2*WORD_W-1:0] pair;
  logic                add_c, add_v, wr, is_rnd;
  logic [WORD_W-1:0]   lim_data;
  logic                lim_sat;

  assign opa    = in_q[src_a_i];
  assign opb    = in_q[src_b_i];
  assign cur    = acc_q[dst_i];
  assign is_rnd = (op_i == OP_RND);
  assign pair   = src_a_i[1] ? {in_q[3], in_q[2]} : {in_q[1], in_q[0]};

  fam_mul #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_mul (
    .a_i(opa), .b_i(opb), .uns_i(uns_i), .prod_o(prod)
  );

  fam_addsub #(.W(ACC_W)) u_add (
    .a_i(cur), .b_i(is_rnd ? HALF : prod), .sub_i(op_i == OP_MSUB),
    .sum_o(sum), .c_o(add_c), .v_o(add_v)
  );

  fam_round #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_rnd (
    .lsw_i(cur[WORD_W-1:0]), .sum_hi_i(sum[ACC_W-1:WORD_W]),
    .conv_i(!rnd_tc_i), .rnd_o(rnd)
  );

  fam_limit #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_lim (
    .hi_i(acc_q[rd_sel_i][ACC_W-1:WORD_W]), .data_o(lim_data), .sat_o(lim_sat)
  );

  always_comb begin
    res  = cur;
    wr   = 1'b1;
    nf.v = 1'b0;
    nf.c = 1'b0;
    case (op_i)
      OP_MPY:  res = prod;
      OP_MAC, OP_MSUB: begin
        res  = sum;
        nf.v = add_v;
        nf.c = add_c;
      end
      OP_RND: begin
        res  = rnd;
        nf.v = add_v;
        nf.c = add_c;
      end
      OP_AND:  res[MSW_HI:WORD_W] = cur[MSW_HI:WORD_W] & opa;
      OP_OR:   res[MSW_HI:WORD_W] = cur[MSW_HI:WORD_W] | opa;
      OP_EOR:  res[MSW_HI:WORD_W] = cur[MSW_HI:WORD_W] ^ opa;
      OP_NOT:  res[MSW_HI:WORD_W] = ~cur[MSW_HI:WORD_W];
      OP_MOVE: res = {{EXT_W{pair[MSW_HI]}}, pair};
      OP_CLR:  res = '0;
      default: wr = 1'b0;
    endcase
    nf.n = res[ACC_W-1];
    nf.z = (res == '0);
    nf.e = !((&res[ACC_W-1:MSW_HI]) || !(|res[ACC_W-1:MSW_HI]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) in_q[i] <= '0;
    end else if (ld_en_i) begin
      in_q[ld_sel_i] <= ld_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NACC; i++) acc_q[i] <= '0;
      flags_q <= '0;
    end else if (wr) begin
      acc_q[dst_i] <= res;
      flags_q      <= nf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) limit_q <= 1'b0;
    else if (rd_en_i && lim_sat) limit_q <= 1'b1;
  end

  assign rd_data_o = lim_data;
  assign limit_o   = limit_q;
  assign flags_o   = flags_q;
  assign acc_a_o   = acc_q[0];
  assign acc_b_o   = acc_q[1];

  AST_LOGIC_KEEPS_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i inside {OP_AND, OP_OR, OP_EOR, OP_NOT}) && !dst_i) |=>
      (acc_a_o[ACC_W-1:2*WORD_W] == $past(acc_a_o[ACC_W-1:2*WORD_W])) &&
      (acc_a_o[WORD_W-1:0] == $past(acc_a_o[WORD_W-1:0]))); // R7

  AST_RND_CLEARS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RND && dst_i) |=> (acc_b_o[WORD_W-1:0] == '0)); // R5

  AST_LIMIT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_o |=> limit_o); // R9

  AST_NOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NOP) |=> ($stable(acc_a_o) && $stable(acc_b_o) && $stable(flags_o))); // R12
endmodule

// File: tb/frac_mac_alu_test.sv
module frac_mac_alu_test;
  import frac_alu_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic dst_i = 0, uns_i = 0, rnd_tc_i = 0, ld_en_i = 0, rd_en_i = 0, rd_sel_i = 0;
  logic [1:0] src_a_i = '0, src_b_i = '0, ld_sel_i = '0;
  logic [15:0] ld_data_i = '0;
  logic [15:0] rd_data_o;
  logic limit_o;
  logic [4:0] flags_o;
  logic [39:0] acc_a_o, acc_b_o;

  frac_mac_alu uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, failures = 0;
  logic [15:0] xr [4];
  logic [39:0] am, bm;
  logic [4:0]  fm;
  logic        lm;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic guard_e(input logic [39:0] r);
    return !((&r[39:31]) || !(|r[39:31]));
  endfunction

  function automatic logic [15:0] lim_exp(input logic [39:0] r);
    if (!guard_e(r)) return r[31:16];
    return r[39] ? 16'h8000 : 16'h7FFF;
  endfunction

  task automatic ld(input int sel, input logic [15:0] v);
    op_i = OP_NOP; ld_en_i = 1; ld_sel_i = 2'(sel); ld_data_i = v;
    @(negedge clk_i);
    ld_en_i = 0; xr[sel] = v;
  endtask

  task automatic run_op(input logic [3:0] op, input logic dst, input logic [1:0] sa,
                        input logic [1:0] sb, input logic uns, input logic tc, input string tag);
    logic [39:0] cur, p, r;
    logic [40:0] s;
    logic v, c, wr;
    longint pa, pb;
    op_i = op; dst_i = dst; src_a_i = sa; src_b_i = sb; uns_i = uns; rnd_tc_i = tc; ld_en_i = 0;
    @(negedge clk_i);
    cur = dst ? bm : am;
    pa = uns ? longint'(xr[sa]) : longint'($signed(xr[sa]));
    pb = uns ? longint'(xr[sb]) : longint'($signed(xr[sb]));
    p = 40'(pa * pb * 2);
    r = cur; v = 0; c = 0; wr = 1;
    case (op)
      4'd1: r = p;
      4'd2: begin s = {1'b0, cur} + {1'b0, p}; r = s[39:0]; c = s[40];
                  v = (cur[39] == p[39]) && (r[39] != cur[39]); end
      4'd3: begin r = cur - p; c = cur < p; v = (cur[39] != p[39]) && (r[39] != cur[39]); end
      4'd4: begin s = {1'b0, cur} + 41'h8000; r = s[39:0]; c = s[40];
                  v = !cur[39] && r[39];
                  if (!tc && cur[15:0] == 16'h8000) r[16] = 1'b0;
                  r[15:0] = '0; end
      4'd5: r[31:16] = cur[31:16] & xr[sa];
      4'd6: r[31:16] = cur[31:16] | xr[sa];
      4'd7: r[31:16] = cur[31:16] ^ xr[sa];
      4'd8: r[31:16] = ~cur[31:16];
      4'd9: r = sa[1] ? {{8{xr[3][15]}}, xr[3], xr[2]} : {{8{xr[1][15]}}, xr[1], xr[0]};
      4'd10: r = '0;
      default: wr = 0;
    endcase
    if (wr) begin
      if (dst) bm = r; else am = r;
      fm = {guard_e(r), r[39], r == 40'd0, v, c};
    end
    check({tag, " acc_a"}, acc_a_o, am);
    check({tag, " acc_b"}, acc_b_o, bm);
    check({tag, " flags"}, flags_o, fm);
  endtask

  task automatic rd_chk(input logic sel, input string tag);
    logic [39:0] a;
    op_i = OP_NOP; rd_sel_i = sel; rd_en_i = 1;
    @(negedge clk_i);
    rd_en_i = 0;
    a = sel ? bm : am;
    lm = lm | guard_e(a);
    check({tag, " rd_data"}, rd_data_o, lim_exp(a));
    check({tag, " limit"}, limit_o, lm);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] vals [8];
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h4000, 16'hC000, 16'h1234};
    for (int i = 0; i < 4; i++) xr[i] = '0;
    am = '0; bm = '0; fm = '0; lm = 0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 acc_a", acc_a_o, 40'd0);
    check("R1 acc_b", acc_b_o, 40'd0);
    check("R1 flags", flags_o, 5'd0);
    check("R1 limit", limit_o, 1'b0);
    rst_ni = 1;
    @(negedge clk_i);
    run_op(OP_MOVE, 0, 2'd0, 2'd0, 0, 0, "R1 x-pair");
    run_op(OP_MOVE, 1, 2'd2, 2'd0, 0, 0, "R1 y-pair");
    // R2 R3 R11: product sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        ld(1, vals[i]);
        ld(2, vals[j]);
        run_op(OP_MPY, 1'(j), 2'd1, 2'd2, 0, 0, "R2 R11 mpy");
        run_op(OP_MPY, 1'(i), 2'd2, 2'd1, 1, 0, "R3 mpy-uns");
      end
    end
    // R4 R10: back-to-back accumulate into overflow
    ld(0, 16'h8000); ld(1, 16'h8000);
    run_op(OP_MPY, 1, 2'd0, 2'd0, 0, 0, "R4 seed");
    for (int k = 0; k < 300; k++) run_op(OP_MAC, 1, 2'd0, 2'd1, 0, 0, "R4 R10 mac");
    for (int k = 0; k < 20; k++) run_op(OP_MSUB, 1, 2'd1, 2'd0, 0, 0, "R4 R10 msub");
    ld(2, 16'hFFFF); ld(3, 16'h7FFF);
    run_op(OP_CLR, 0, 2'd0, 2'd0, 0, 0, "R8 clr");
    for (int k = 0; k < 6; k++) run_op(OP_MSUB, 0, 2'd2, 2'd3, 1, 0, "R3 R10 msub-uns");
    for (int k = 0; k < 6; k++) run_op(OP_MAC, 0, 2'd2, 2'd2, 1, 0, "R3 R10 mac-uns");
    run_op(OP_RND, 0, 2'd2, 2'd2, 1, 1, "R3 rnd-uns-ignored");
    // R5 R6 R8: rounding sweep via pair loads
    for (int h = 0; h < 6; h++) begin
      for (int l = 0; l < 5; l++) begin
        for (int m = 0; m < 2; m++) begin
          logic [15:0] hv [6];
          logic [15:0] lv [5];
          hv = '{16'h0000, 16'h0001, 16'h7FFE, 16'h7FFF, 16'hFFFF, 16'h8000};
          lv = '{16'h0000, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF};
          ld(1, hv[h]); ld(0, lv[l]);
          run_op(OP_MOVE, 1'(m), 2'd0, 2'd0, 0, 0, "R8 move");
          run_op(OP_RND, 1'(m), 2'd0, 2'd0, 0, 1'(m), m ? "R5 rnd-tc" : "R6 rnd-conv");
        end
      end
    end
    // R7: logic ops on a value with live guard and low bits
    ld(0, 16'h4000); ld(1, 16'h4000);
    run_op(OP_MPY, 0, 2'd0, 2'd1, 0, 0, "R7 seed");
    for (int k = 0; k < 40; k++) run_op(OP_MAC, 0, 2'd0, 2'd1, 0, 0, "R7 grow");
    ld(3, 16'h5A3C); ld(2, 16'hA5C3);
    run_op(OP_MSUB, 0, 2'd3, 2'd2, 0, 0, "R7 lowbits");
    for (int k = 5; k <= 8; k++) begin
      run_op(4'(k), 0, 2'd3, 2'd0, 0, 0, "R7 logic");
      run_op(4'(k), 0, 2'd2, 2'd0, 1, 0, "R7 logic");
    end
    // R12: no-op and undefined opcodes
    for (int k = 11; k < 16; k++) run_op(4'(k), 0, 2'd0, 2'd1, 0, 0, "R12 undef");
    run_op(OP_NOP, 1, 2'd0, 2'd1, 0, 0, "R12 nop");
    // R9: limiter and sticky flag
    ld(1, 16'h1234); ld(0, 16'h0000);
    run_op(OP_MOVE, 1, 2'd0, 2'd0, 0, 0, "R9 inrange");
    rd_chk(1, "R9 in-range");
    ld(1, 16'h8000); ld(2, 16'h7FFF); ld(3, 16'h8000);
    run_op(OP_MOVE, 1, 2'd0, 2'd0, 0, 0, "R9 negedge");
    rd_chk(1, "R9 min-unsat");
    run_op(OP_MPY, 1, 2'd3, 2'd3, 0, 0, "R9 plus-one");
    rd_chk(0, "R9 a-read");
    rd_chk(1, "R9 pos-sat");
    rd_chk(0, "R9 sticky");
    run_op(OP_CLR, 1, 2'd0, 2'd0, 0, 0, "R9 clr");
    run_op(OP_MSUB, 1, 2'd3, 2'd3, 0, 0, "R9 neg1");
    run_op(OP_MSUB, 1, 2'd3, 2'd3, 0, 0, "R9 neg2");
    rd_chk(1, "R9 neg-sat");
    rd_en_i = 0; rd_sel_i = 1;
    @(negedge clk_i);
    check("R9 no-strobe read", rd_data_o, lim_exp(bm));
    op_i = OP_NOP;
    @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule